// File: doc/BRIEF.md
# Predicated SIMD Lane Execution Unit

This block executes one decoded vector instruction per clock across a row of identical lanes. Every lane shares the same opcode and register indices. Each lane works on its own 32-bit slice of the vector registers. A per-lane mask decides which lanes may write their result back. Lanes whose mask bit is clear still compute, but their result is dropped and the destination slice keeps its old value.

Divergent if/else code runs as two passes over the same lanes. A compare instruction turns a per-lane "greater than zero" test into the mask, and the then-side instructions follow. An invert instruction flips the mask so that the else-side instructions run on the remaining lanes. A clear instruction then restores all lanes for unconditional code. Only one level of condition is held. A second compare inside an open condition is refused and raises a sticky error flag.

Two counters track how much of the lane array does useful work. One adds the lane count for every issued instruction. The other adds the number of lanes enabled when that instruction was issued. A load port and a combinational read port connect the vector register file to the surrounding pipeline.

Top module: `simd_pred_unit`

## Requirements
- R1: After reset the mask is all ones, both counters are zero, the error flag is low and every register lane reads zero.
- R2: Opcode 1 (add) writes src_a + src_b, modulo 2^32, into each enabled lane of dst. The result is visible on the read port the cycle after issue.
- R3: Opcode 2 (multiply) writes the low 32 bits of src_a * src_b into each enabled lane of dst.
- R4: Opcode 3 (immediate move) writes the 32-bit immediate into every enabled lane of dst.
- R5: A lane whose mask bit is 0 keeps its old destination value when a writing opcode (1, 2 or 3) is issued.
- R6: Opcode 4 (compare), issued outside a condition, sets mask bit i to 1 exactly when lane i of src_a, read as signed, is greater than zero. It then opens a condition.
- R7: Opcode 5 (invert) replaces the mask with its bitwise complement.
- R8: Opcode 6 (clear) sets the mask to all ones, closes the condition and clears the error flag.
- R9: Opcode 4 issued while a condition is open leaves the mask unchanged and sets the error flag. The flag stays set until opcode 6 is issued.
- R10: Each issued instruction of any opcode adds LANES to the slot counter. It also adds the number of ones in the mask in effect at issue to the active counter. Opcodes 0 and 7 do nothing else.
- R11: A load writes all lanes of the selected register and is visible on the read port the next cycle. The read port follows rd_idx with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Instruction issued this cycle |
| iss_op | input | 3 | Opcode |
| iss_dst | input | 3 | Destination register index |
| iss_srca | input | 3 | First source register index |
| iss_srcb | input | 3 | Second source register index |
| iss_imm | input | 32 | Immediate for opcode 3 |
| ld_en | input | 1 | Load a whole vector register |
| ld_idx | input | 3 | Load target register |
| ld_data | input | 256 | Load data, lane i in bits 32i+31:32i |
| rd_idx | input | 3 | Read port register index |
| rd_data | output | 256 | Read port data, same lane layout |
| lane_mask | output | 8 | Current lane mask |
| nest_err | output | 1 | Nested condition error flag |
| active_cnt | output | 32 | Sum of enabled lanes over issued instructions |
| slot_cnt | output | 32 | Sum of lane slots over issued instructions |

## Verification
A corrupted mask shows at the ports one cycle later in three places: on lane_mask, in the active counter's next step, and as wrong or missing writes that the read port exposes. A condition flag stuck open or closed shows on the next compare, which either raises the error flag when it should not or fails to raise it. The bench loads distinct values into each lane, so every mask pattern, including a single enabled lane, traces back to particular lanes. Register slices are read back after each then/else pass to confirm that the disabled lanes held their values.

// File: rtl/simd_pkg.sv
package simd_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_ADD   = 3'd1,
        OP_MUL   = 3'd2,
        OP_MOVI  = 3'd3,
        OP_SETGT = 3'd4,
        OP_INV   = 3'd5,
        OP_CLR   = 3'd6,
        OP_RSV   = 3'd7
    } op_e;
endpackage

// File: rtl/simd_lane.sv
module simd_lane
    import simd_pkg::*;
#(
    parameter int LANE_W = 32
) (
    input  op_e               op,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  logic [LANE_W-1:0] imm,
    output logic [LANE_W-1:0] res,
    output logic              gt_zero
);
    always_comb begin
        unique case (op)
            OP_ADD:  res = a + b;
            OP_MUL:  res = a * b;
            OP_MOVI: res = imm;
            default: res = a;
        endcase
        gt_zero = $signed(a) > 0;
    end
endmodule

// File: rtl/simd_mask_ctrl.sv
module simd_mask_ctrl
    import simd_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  op_e              op,
    input  logic [LANES-1:0] gt_vec,
    output logic [LANES-1:0] mask,
    output logic             err
);
    typedef struct packed {
        logic [LANES-1:0] mask;
        logic             in_cond;
        logic             err;
    } mstate_t;

    mstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (valid) begin
            unique case (op)
                OP_SETGT: begin
                    if (st_q.in_cond) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.mask    = gt_vec;
                        st_d.in_cond = 1'b1;
                    end
                end
                OP_INV: st_d.mask = ~st_q.mask;
                OP_CLR: begin
                    st_d.mask    = '1;
                    st_d.in_cond = 1'b0;
                    st_d.err     = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mask: '1, in_cond: 1'b0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mask = st_q.mask;
    assign err  = st_q.err;

    assert_mask_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == OP_CLR) |=> (mask == '1 && !err));

    assert_mask_invert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == OP_INV) |=> (mask == ~$past(mask)));

    assert_nest_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == OP_SETGT && $past(valid) && $past(op) == OP_SETGT && !$past(err))
        |=> (err && $stable(mask)));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(valid && op == OP_CLR)) |=> err);
endmodule

// File: rtl/simd_util_ctr.sv
module simd_util_ctr #(
    parameter int LANES = 8,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [LANES-1:0] mask,
    output logic [CNT_W-1:0] active,
    output logic [CNT_W-1:0] slots
);
    localparam logic [CNT_W-1:0] LANE_STEP = CNT_W'(LANES);

    typedef struct packed {
        logic [CNT_W-1:0] act;
        logic [CNT_W-1:0] slot;
    } cstate_t;

    cstate_t st_d, st_q;
    logic [CNT_W-1:0] pop;

    always_comb begin
        pop = '0;
        for (int i = 0; i < LANES; i++) begin
            pop = pop + CNT_W'(mask[i]);
        end
        st_d = st_q;
        if (valid) begin
            st_d.act  = st_q.act + pop;
            st_d.slot = st_q.slot + LANE_STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.act;
    assign slots  = st_q.slot;

    assert_slot_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> (slots == $past(slots) + LANE_STEP));

    assert_active_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> ((active - $past(active)) <= LANE_STEP &&
                   (active - $past(active)) == CNT_W'($countones($past(mask)))));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> ($stable(active) && $stable(slots)));
endmodule

// File: rtl/simd_pred_unit.sv
module simd_pred_unit
    import simd_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int LANE_W = 32,
    parameter int NREGS  = 8,
    parameter int CNT_W  = 32,
    localparam int RW    = $clog2(NREGS),
    localparam int VW    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [2:0]        iss_op,
    input  logic [RW-1:0]     iss_dst,
    input  logic [RW-1:0]     iss_srca,
    input  logic [RW-1:0]     iss_srcb,
    input  logic [LANE_W-1:0] iss_imm,
    input  logic              ld_en,
    input  logic [RW-1:0]     ld_idx,
    input  logic [VW-1:0]     ld_data,
    input  logic [RW-1:0]     rd_idx,
    output logic [VW-1:0]     rd_data,
    output logic [LANES-1:0]  lane_mask,
    output logic              nest_err,
    output logic [CNT_W-1:0]  active_cnt,
    output logic [CNT_W-1:0]  slot_cnt
);
    typedef logic [LANES-1:0][LANE_W-1:0] vec_t;

    typedef struct packed {
        logic [NREGS-1:0][LANES-1:0][LANE_W-1:0] rf;
    } rstate_t;

    rstate_t st_d, st_q;
    op_e     op;
    vec_t    va, vb, vres;
    logic [LANES-1:0] gt_vec;
    logic    is_wr;

    assign op    = op_e'(iss_op);
    assign va    = st_q.rf[iss_srca];
    assign vb    = st_q.rf[iss_srcb];
    assign is_wr = iss_valid && (op == OP_ADD || op == OP_MUL || op == OP_MOVI);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        simd_lane #(.LANE_W(LANE_W)) u_lane (
            .op      (op),
            .a       (va[l]),
            .b       (vb[l]),
            .imm     (iss_imm),
            .res     (vres[l]),
            .gt_zero (gt_vec[l])
        );
    end

    simd_mask_ctrl #(.LANES(LANES)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (iss_valid),
        .op     (op),
        .gt_vec (gt_vec),
        .mask   (lane_mask),
        .err    (nest_err)
    );

    simd_util_ctr #(.LANES(LANES), .CNT_W(CNT_W)) u_util (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (iss_valid),
        .mask   (lane_mask),
        .active (active_cnt),
        .slots  (slot_cnt)
    );

    always_comb begin
        st_d = st_q;
        if (ld_en) begin
            st_d.rf[ld_idx] = ld_data;
        end
        if (is_wr) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_mask[l]) begin
                    st_d.rf[iss_dst][l] = vres[l];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rf[rd_idx];

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        assert_masked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (is_wr && !lane_mask[l] && !ld_en)
            |=> (st_q.rf[$past(iss_dst)][l] == $past(st_q.rf[iss_dst][l])));
    end
endmodule

// File: tb/simd_pred_unit_test.sv
module simd_pred_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 8;
    localparam int LW = 32;
    localparam int NR = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iss_valid = 1'b0;
    logic [2:0] iss_op = 3'd0, iss_dst = 3'd0, iss_srca = 3'd0, iss_srcb = 3'd0;
    logic [31:0] iss_imm = '0;
    logic ld_en = 1'b0;
    logic [2:0] ld_idx = 3'd0;
    logic [LANES*LW-1:0] ld_data = '0;
    logic [2:0] rd_idx = 3'd0;
    logic [LANES*LW-1:0] rd_data;
    logic [LANES-1:0] lane_mask;
    logic nest_err;
    logic [31:0] active_cnt, slot_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_pred_unit uut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_dst(iss_dst), .iss_srca(iss_srca), .iss_srcb(iss_srcb), .iss_imm(iss_imm),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data), .rd_idx(rd_idx),
        .rd_data(rd_data), .lane_mask(lane_mask), .nest_err(nest_err),
        .active_cnt(active_cnt), .slot_cnt(slot_cnt)
    );

    typedef struct {
        logic [LANES-1:0] mask;
        logic             err;
        logic [31:0]      act;
        logic [31:0]      slot;
        string            req;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [31:0] m_rf [NR][LANES];
    logic [LANES-1:0] m_mask = '1;
    logic m_in = 1'b0, m_err = 1'b0;
    logic [31:0] m_act = '0, m_slot = '0;

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // driver: issue one instruction, update the reference model, queue the expectation
    task automatic issue(input logic [2:0] op, input logic [2:0] d, input logic [2:0] a,
                         input logic [2:0] b, input logic [31:0] imm, input string req);
        logic [31:0] r;
        exp_t e;
        @(negedge clk);
        iss_valid = 1'b1; iss_op = op; iss_dst = d; iss_srca = a; iss_srcb = b; iss_imm = imm;
        m_slot = m_slot + LANES;
        m_act  = m_act + $countones(m_mask);
        if (op == 3'd1 || op == 3'd2 || op == 3'd3) begin
            for (int l = 0; l < LANES; l++) begin
                r = (op == 3'd1) ? m_rf[a][l] + m_rf[b][l] :
                    (op == 3'd2) ? m_rf[a][l] * m_rf[b][l] : imm;
                if (m_mask[l]) m_rf[d][l] = r;
            end
        end else if (op == 3'd4) begin
            if (m_in) m_err = 1'b1;
            else begin
                for (int l = 0; l < LANES; l++) m_mask[l] = $signed(m_rf[a][l]) > 0;
                m_in = 1'b1;
            end
        end else if (op == 3'd5) begin
            m_mask = ~m_mask;
        end else if (op == 3'd6) begin
            m_mask = '1; m_in = 1'b0; m_err = 1'b0;
        end
        e.mask = m_mask; e.err = m_err; e.act = m_act; e.slot = m_slot; e.req = req;
        q.push_back(e);
        @(posedge clk);
        #1 iss_valid = 1'b0;
    endtask

    // monitor: compare the state produced by each issued instruction
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (lane_mask !== e.mask || nest_err !== e.err ||
                    active_cnt !== e.act || slot_cnt !== e.slot) begin
                    fails++;
                    $display("FAIL %s: mask=%h err=%b act=%0d slot=%0d expected mask=%h err=%b act=%0d slot=%0d",
                             e.req, lane_mask, nest_err, active_cnt, slot_cnt,
                             e.mask, e.err, e.act, e.slot);
                end
            end
        end
    end

    task automatic load(input logic [2:0] idx, input logic [31:0] v [LANES]);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = idx;
        for (int l = 0; l < LANES; l++) begin
            ld_data[l*LW +: LW] = v[l];
            m_rf[idx][l] = v[l];
        end
        @(posedge clk);
        #1 ld_en = 1'b0;
    endtask

    task automatic check_reg(input logic [2:0] idx, input string req);
        bit bad = 1'b0;
        @(negedge clk);
        rd_idx = idx;
        #1;
        checks++;
        for (int l = 0; l < LANES; l++) begin
            if (rd_data[l*LW +: LW] !== m_rf[idx][l]) begin
                bad = 1'b1;
                $display("FAIL %s: reg %0d lane %0d = %h expected %h",
                         req, idx, l, rd_data[l*LW +: LW], m_rf[idx][l]);
            end
        end
        if (bad) fails++;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v [LANES];
        for (int r = 0; r < NR; r++)
            for (int l = 0; l < LANES; l++) m_rf[r][l] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (lane_mask !== '1 || nest_err !== 1'b0 || active_cnt !== 0 || slot_cnt !== 0) begin
            fails++;
            $display("FAIL R1: mask=%h err=%b act=%0d slot=%0d expected ff 0 0 0",
                     lane_mask, nest_err, active_cnt, slot_cnt);
        end
        check_reg(3'd2, "R1");

        // R11: load distinct lane values
        v = '{32'd5, -32'sd3, 32'd0, 32'd7, -32'sd1, 32'd2, -32'sd8, 32'd9};
        load(3'd1, v);
        check_reg(3'd1, "R11");
        v = '{32'h7fffffff, 32'd1, 32'hffffffff, 32'd10, 32'd3, 32'h10000, 32'd4, 32'd6};
        load(3'd4, v);
        check_reg(3'd4, "R11");

        // R4, R2, R3 with all lanes enabled
        issue(3'd3, 3'd2, 3'd0, 3'd0, 32'hdeadbeef, "R4");
        check_reg(3'd2, "R4");
        issue(3'd1, 3'd3, 3'd1, 3'd4, 32'd0, "R2");
        check_reg(3'd3, "R2");
        issue(3'd2, 3'd5, 3'd4, 3'd4, 32'd0, "R3");
        check_reg(3'd5, "R3");

        // R6 then-pass, R7 else-pass, R5 masked lanes hold, R8 restore
        issue(3'd4, 3'd0, 3'd1, 3'd0, 32'd0, "R6");
        issue(3'd3, 3'd2, 3'd0, 3'd0, 32'h11111111, "R5");
        check_reg(3'd2, "R5");
        issue(3'd5, 3'd0, 3'd0, 3'd0, 32'd0, "R7");
        issue(3'd1, 3'd2, 3'd1, 3'd1, 32'd0, "R5");
        check_reg(3'd2, "R5");
        issue(3'd8 - 3'd2, 3'd0, 3'd0, 3'd0, 32'd0, "R8");
        issue(3'd3, 3'd6, 3'd0, 3'd0, 32'h5a5a5a5a, "R8");
        check_reg(3'd6, "R8");

        // R9: nested compare refused, flag sticky until clear
        issue(3'd4, 3'd0, 3'd4, 3'd0, 32'd0, "R6");
        issue(3'd4, 3'd0, 3'd1, 3'd0, 32'd0, "R9");
        issue(3'd5, 3'd0, 3'd0, 3'd0, 32'd0, "R9");
        issue(3'd0, 3'd0, 3'd0, 3'd0, 32'd0, "R9");
        issue(3'd6, 3'd0, 3'd0, 3'd0, 32'd0, "R8");

        // R10: worst divergence, one enabled lane
        v = '{-32'sd1, -32'sd1, -32'sd1, -32'sd1, -32'sd1, 32'd3, -32'sd1, 32'd0};
        load(3'd7, v);
        issue(3'd4, 3'd0, 3'd7, 3'd0, 32'd0, "R6");
        issue(3'd1, 3'd7, 3'd7, 3'd7, 32'd0, "R10");
        issue(3'd7, 3'd0, 3'd0, 3'd0, 32'd0, "R10");
        check_reg(3'd7, "R10");
        issue(3'd5, 3'd0, 3'd0, 3'd0, 32'd0, "R7");
        issue(3'd6, 3'd0, 3'd0, 3'd0, 32'd0, "R8");
        check_reg(3'd1, "R11");

        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule